// File: doc/BRIEF.md
# Two-Channel Bitstream Charge-Balance Converter Counter

This block is the digital side of a first-order charge-balancing converter with two channels. Each channel has an external comparator-like input bit. On every tick the block samples that bit and drives the channel's feedback pin to its complement, which steers an outside RC network toward balance. The block counts, per channel, the ticks on which feedback was driven high over a fixed window of 2^RES_W ticks (256 by default). At the end of the window it publishes one RES_W-bit result per channel and starts the next window from zero.

Both channels share one window counter, so their results are always latched in the same tick. The counters saturate at the all-ones value. A full-scale input, with feedback high on every tick of the window, therefore reads 0xFF instead of wrapping to zero. Comparator bits arrive asynchronously and pass through a two-flop synchronizer before they are used.

The results form an output stream with no back-pressure. A one-cycle `result_valid_o` pulse marks a new pair of results. There is no ready input, because a window cannot be held back. A consumer that misses the pulse can still read the held results until the next window ends.

Top module: `bsadc_counter`

## Requirements
- R1: On each cycle with `tick_i` high, `fb_o[c]` becomes the complement of the synchronized input of channel c; on cycles without a tick, `fb_o` keeps its value.
- R2: `cmp_i` passes through two flip-flops before use: the value on `cmp_i` at clock edge k is the one used by a tick at edge k+2.
- R3: A channel's result equals the number of ticks in the window on which that channel's feedback was driven high.
- R4: The count saturates at 2^RES_W-1: a window with feedback high on all 2^RES_W ticks yields 0xFF (default width) and never 0.
- R5: A window is exactly 2^RES_W ticks; cycles with `tick_i` low neither advance the window nor add to any count.
- R6: Both channels latch their results at the same clock edge; that edge also clears both counts, so the next window starts from zero, including after a saturated window.
- R7: `result_valid_o` is high for exactly one cycle. That cycle is the first one in which the new results are visible.
- R8: `result_o` holds its value between window ends.
- R9: After reset, `result_o`, `fb_o` and `result_valid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample enable; one converter step per high cycle |
| cmp_i | input | NCH | Asynchronous comparator bit per channel (bit c is channel c) |
| fb_o | output | NCH | Feedback drive per channel (bit c is channel c) |
| result_o | output | NCH*RES_W | Results; channel c in bits [c*RES_W +: RES_W] |
| result_valid_o | output | 1 | One-cycle pulse when new results appear |

## Verification
The two channels are driven with a different input pattern in each window:
- Constant high and constant low inputs pin the result at zero and at the saturation value, which separates saturation from wrap-around.
- Alternating and duty-cycle patterns yield mid-scale counts.
- Unequal patterns on the two channels show that the channels cannot leak into each other or latch apart.
- Windows with sparse ticks, and idle stretches with a toggling input, show that only ticks count.

In every cycle the bench also compares feedback, results and the valid pulse against its own model of the synchronizer delay. This catches a wrong number of stages or a wrong window length.

// File: rtl/bsadc_pkg.sv
package bsadc_pkg;
  localparam int unsigned DEF_NCH    = 2;
  localparam int unsigned DEF_RES_W  = 8;
  localparam int unsigned DEF_SYNC_N = 2;
endpackage

// File: rtl/bsadc_sync.sv
module bsadc_sync #(
  parameter int unsigned NCH    = bsadc_pkg::DEF_NCH,
  parameter int unsigned STAGES = bsadc_pkg::DEF_SYNC_N
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] d_i,
  output logic [NCH-1:0] q_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_i[c]};
    end
    assign q_o[c] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/bsadc_window.sv
module bsadc_window #(
  parameter int unsigned RES_W = bsadc_pkg::DEF_RES_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic wrap_o
);
  logic [RES_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = tick_i && (&cnt_q);

  assert_win_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt_q == RES_W'($past(cnt_q) + 1'b1));
  assert_win_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/bsadc_chan.sv
module bsadc_chan #(
  parameter int unsigned RES_W = bsadc_pkg::DEF_RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             latch_i,
  input  logic             smp_i,
  output logic             fb_o,
  output logic [RES_W-1:0] res_o
);
  logic             fb_q;
  logic [RES_W-1:0] acc_q, res_q, acc_inc, acc_nxt;
  logic             hit;

  assign hit     = tick_i && !smp_i;
  assign acc_inc = (&acc_q) ? acc_q : acc_q + 1'b1;
  assign acc_nxt = hit ? acc_inc : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q  <= 1'b0;
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (tick_i) fb_q <= !smp_i;
      if (latch_i) begin
        res_q <= acc_nxt;
        acc_q <= '0;
      end else begin
        acc_q <= acc_nxt;
      end
    end
  end

  assign fb_o  = fb_q;
  assign res_o = res_q;

  assert_fb_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(fb_q));
  assert_acc_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> acc_q >= $past(acc_q));
  assert_acc_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((&acc_q) && !latch_i) |=> (&acc_q));
  assert_acc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> acc_q == '0);
  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_i |=> $stable(res_q));
endmodule

// File: rtl/bsadc_counter.sv
module bsadc_counter #(
  parameter int unsigned NCH    = bsadc_pkg::DEF_NCH,
  parameter int unsigned RES_W  = bsadc_pkg::DEF_RES_W,
  parameter int unsigned SYNC_N = bsadc_pkg::DEF_SYNC_N
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [NCH-1:0]       cmp_i,
  output logic [NCH-1:0]       fb_o,
  output logic [NCH*RES_W-1:0] result_o,
  output logic                 result_valid_o
);
  logic [NCH-1:0] smp;
  logic           wrap;
  logic           valid_q;

  bsadc_sync #(.NCH(NCH), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(smp)
  );

  bsadc_window #(.RES_W(RES_W)) u_win (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wrap_o(wrap)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bsadc_chan #(.RES_W(RES_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .latch_i(wrap),
      .smp_i(smp[c]), .fb_o(fb_o[c]), .res_o(result_o[c*RES_W +: RES_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= wrap;
  end
  assign result_valid_o = valid_q;

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  assert_valid_follows_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(tick_i));
endmodule

// File: tb/bsadc_counter_tb.sv
module bsadc_counter_tb;
  localparam int NCH = 2;
  localparam int W   = 8;
  localparam int WIN = 1 << W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_i = 1'b0;
  logic [NCH-1:0]   cmp_i = '0;
  logic [NCH-1:0]   fb_o;
  logic [NCH*W-1:0] result_o;
  logic             result_valid_o;

  int checks = 0;
  int errors = 0;

  logic [NCH-1:0] m_s1 = '0, m_s2 = '0, e_fb = '0;
  int             m_cnt [NCH];
  int             e_res [NCH];
  int             m_win = 0;
  logic           e_valid = 1'b0;
  int             cyc = 0;

  always #5 clk = ~clk;

  bsadc_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cmp_i(cmp_i),
    .fb_o(fb_o), .result_o(result_o), .result_valid_o(result_valid_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic logic pat(input int p, input int ch, input int i);
    case (p)
      0: return 1'b1;
      1: return 1'b0;
      2: return 1'(i % 2);
      3: return 1'((i % 7) < (3 + ch));
      4: return 1'(ch);
      5: return 1'(((i * 37 + ch * 11) % 256) < 100);
      default: return 1'(((i / 3) % 5) == ch);
    endcase
  endfunction

  // one clock: drive at negedge, model the two-stage sync and window, check at next negedge
  task automatic step(input logic [NCH-1:0] din, input logic tk, input string rtag);
    logic [NCH-1:0] old2;
    cmp_i  = din;
    tick_i = tk;
    old2 = m_s2;
    m_s2 = m_s1;
    m_s1 = din;
    e_valid = 1'b0;
    if (tk) begin
      e_fb = ~old2;
      for (int c = 0; c < NCH; c++) if (e_fb[c]) m_cnt[c]++;
      m_win++;
      if (m_win == WIN) begin
        for (int c = 0; c < NCH; c++) begin
          e_res[c] = (m_cnt[c] > WIN - 1) ? WIN - 1 : m_cnt[c];
          m_cnt[c] = 0;
        end
        m_win = 0;
        e_valid = 1'b1;
      end
    end
    @(negedge clk);
    cyc++;
    chk("R1/R2 fb", int'(fb_o), int'(e_fb));
    chk("R7 valid", int'(result_valid_o), int'(e_valid));
    for (int c = 0; c < NCH; c++)
      chk(e_valid ? rtag : "R8 hold", int'(result_o[c*W +: W]), e_res[c]);
  endtask

  task automatic run_window(input int p, input int period, input string rtag);
    for (int i = 0; i < WIN * period; i++) begin
      logic [NCH-1:0] d;
      for (int c = 0; c < NCH; c++) d[c] = pat(p, c, i);
      step(d, (i % period) == 0, rtag);
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; e_res[c] = 0; end
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 fb", int'(fb_o), 0);
    chk("R9 valid", int'(result_valid_o), 0);
    chk("R9 result", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_window(0, 1, "R3 zero");
    run_window(1, 1, "R4 saturate");
    run_window(1, 1, "R4 saturate again");
    run_window(2, 1, "R6 after saturation");
    run_window(3, 1, "R3 duty");
    run_window(4, 1, "R6 split channels");
    run_window(5, 1, "R3 scrambled");
    // idle stretch: toggling input, no ticks (R5, R8)
    for (int i = 0; i < 40; i++) step(NCH'(i), 1'b0, "R5 idle");
    run_window(6, 3, "R5 sparse ticks");
    run_window(1, 2, "R5 sparse saturate");
    run_window(2, 1, "R3 alternate");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule